// File: doc/BRIEF.md
# Memory Byte Scan and Skip Engine

This block walks byte-addressed memory from a start pointer and compares each candidate position against a needle that is one to four bytes wide. In scan mode it looks for the first position where the whole needle appears. In skip mode it moves forward over consecutive copies of the needle and stops on the first position that is not a copy. A typical skip use is passing over a run of space characters (0x20) to land on the first non-space byte.

A single `start_i` pulse captures the mode, start address, needle, needle width and maximum length. The engine then reads memory through a synchronous byte-wide read port, one byte per clock while it fetches a candidate. Read data returns the cycle after the request. When it finishes, it pulses `done_o` for one cycle. It also presents the final pointer and a zero flag, and both hold until the next completion. The pointer is 24 bits wide and wraps modulo 2^24.

Top module: `needle_walk_engine`

## Requirements
- R1: `needle_len_i` gives the needle width as bytes minus one (0 = 1 byte … 3 = 4 bytes). Needle byte k (`needle_i[8k+7:8k]`) is compared with memory at candidate address + k, so the least significant byte sits at the lowest address. A candidate matches only when all its bytes are equal.
- R2: In scan mode (`skip_mode_i`=0), candidates advance by one byte. The engine stops at the first matching candidate with `ptr_o` equal to that address and `zero_o`=1.
- R3: In scan mode, if none of the `max_len_i` candidates matches, `ptr_o` = start + `max_len_i` and `zero_o`=0.
- R4: In skip mode (`skip_mode_i`=1), candidates advance by the needle width while they match. The engine stops at the first non-matching candidate with `ptr_o` equal to that address and `zero_o`=1.
- R5: In skip mode, if all `max_len_i` candidates match, `ptr_o` = start + `max_len_i` × width and `zero_o`=0.
- R6: A start with `max_len_i`=0 issues no read. `done_o` rises on the next cycle with `ptr_o` = start address and `zero_o`=0.
- R7: `done_o` is high for exactly one cycle per accepted start. `ptr_o` and `zero_o` are 0 after reset and hold their value until the next completion.
- R8: A `start_i` that arrives while a walk is in progress is ignored. The walk finishes with its own result and a single `done_o`.
- R9: Candidate and read addresses wrap modulo 2^24.
- R10: Each candidate is read as width consecutive byte reads, one per clock. Read data is expected one cycle after `mem_rd_o`. Reads occur only while a walk is in progress, so a walk over n candidates of width w issues exactly n·w reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse; operands are captured on it |
| skip_mode_i | input | 1 | 0 = scan for needle, 1 = skip over needle |
| start_addr_i | input | 24 | First candidate address |
| needle_i | input | 32 | Needle value, byte 0 at lowest address |
| needle_len_i | input | 2 | Needle width in bytes minus one |
| max_len_i | input | 24 | Maximum number of candidates examined |
| mem_rd_o | output | 1 | Memory read request |
| mem_addr_o | output | 24 | Memory read address |
| mem_data_i | input | 8 | Read data, valid the cycle after the request |
| done_o | output | 1 | One-cycle completion pulse |
| zero_o | output | 1 | Outcome flag (R2 to R6) |
| ptr_o | output | 24 | Final pointer |

## Verification
A corrupted candidate pointer or byte index shows up at once on `mem_addr_o` as a read outside the expected sequence. It then shows at completion as a wrong `ptr_o` and read count. A lost match accumulator, or a wrong needle lane, changes the stop position and `zero_o` of the walk it occurs in. This is visible when `done_o` fires, which is at most (width+1)·`max_len_i` cycles after the start. A stuck control state shows as a missing or repeated `done_o` pulse, or as reads continuing after completion.

// File: rtl/nwe_pkg.sv
// Shared types for the needle walk engine.
package nwe_pkg;
    // Control states: idle, fetching needle bytes, deciding on a candidate.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2
    } nwe_state_e;
endpackage

// File: rtl/nwe_lane_match.sv
// Selects one needle byte by lane index and compares it with a returned
// memory byte. Assumes NEEDLE_BYTES is a power of two, so every index
// value names a lane.
module nwe_lane_match #(
    parameter int NEEDLE_BYTES = 4,
    parameter int IDX_W        = 2,
    parameter int NEEDLE_W     = 32
) (
    input  logic [NEEDLE_W-1:0] needle_i,
    input  logic [IDX_W-1:0]    lane_i,
    input  logic [7:0]          data_i,
    output logic                eq_o
);
    logic [7:0] lanes [NEEDLE_BYTES];

    // Split the needle into byte lanes, lane 0 = lowest address (R1).
    for (genvar g = 0; g < NEEDLE_BYTES; g++) begin : g_lane
        assign lanes[g] = needle_i[8*g +: 8];
    end

    // Byte compare of the selected lane.
    always_comb eq_o = (lanes[lane_i] == data_i);
endmodule

// File: rtl/nwe_ptr_step.sv
// Address arithmetic: read address of the current byte and base of the
// next candidate. All sums wrap at ADDR_W bits (R9).
module nwe_ptr_step #(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 2
) (
    input  logic [ADDR_W-1:0] cand_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [IDX_W-1:0]  wlast_i,
    input  logic              skip_i,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic [ADDR_W-1:0] next_cand_o
);
    logic [ADDR_W-1:0] step;

    // Byte address inside the candidate.
    always_comb fetch_addr_o = cand_i + ADDR_W'(idx_i);

    // Scan steps one byte, skip steps one needle width (R2, R4).
    always_comb step = skip_i ? (ADDR_W'(wlast_i) + ADDR_W'(1)) : ADDR_W'(1);

    // Next candidate base.
    always_comb next_cand_o = cand_i + step;
endmodule

// File: rtl/nwe_outcome.sv
// Decides, once a candidate is fully compared, whether the walk ends and
// with which pointer and flag. Scan ends on a match, skip ends on a
// mismatch; both end when the last allowed candidate was examined.
module nwe_outcome #(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 24
) (
    input  logic              skip_i,
    input  logic              cand_eq_i,
    input  logic [LEN_W-1:0]  left_i,
    input  logic [ADDR_W-1:0] cand_i,
    input  logic [ADDR_W-1:0] next_cand_i,
    output logic              finish_o,
    output logic [ADDR_W-1:0] fin_ptr_o,
    output logic              fin_zero_o
);
    logic hit;
    logic last;

    // A hit is the condition the current mode is looking for.
    always_comb hit = skip_i ? !cand_eq_i : cand_eq_i;

    // Final candidate of the allowed range.
    always_comb last = (left_i == LEN_W'(1));

    // Result: stop on a hit (R2, R4), or past the range on exhaustion (R3, R5).
    always_comb begin
        finish_o   = hit || last;
        fin_ptr_o  = hit ? cand_i : next_cand_i;
        fin_zero_o = hit;
    end
endmodule

// File: rtl/needle_walk_engine.sv
// Top of the needle walk engine. Captures operands on start_i, fetches the
// bytes of each candidate back to back over a read port with one cycle of
// latency, accumulates the compare and moves to the next candidate until
// the mode's stop condition or the length limit. Assumes the memory returns
// data for every request exactly one cycle later.
module needle_walk_engine
    import nwe_pkg::*;
#(
    parameter int ADDR_W       = 24,
    parameter int NEEDLE_BYTES = 4,
    parameter int LEN_W        = 24,
    localparam int IDX_W       = $clog2(NEEDLE_BYTES),
    localparam int NEEDLE_W    = 8 * NEEDLE_BYTES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                skip_mode_i,
    input  logic [ADDR_W-1:0]   start_addr_i,
    input  logic [NEEDLE_W-1:0] needle_i,
    input  logic [IDX_W-1:0]    needle_len_i,
    input  logic [LEN_W-1:0]    max_len_i,
    output logic                mem_rd_o,
    output logic [ADDR_W-1:0]   mem_addr_o,
    input  logic [7:0]          mem_data_i,
    output logic                done_o,
    output logic                zero_o,
    output logic [ADDR_W-1:0]   ptr_o
);
    nwe_state_e          state_q;
    logic [ADDR_W-1:0]   cand_q;
    logic [IDX_W-1:0]    idx_q;
    logic [IDX_W-1:0]    wlast_q;
    logic [LEN_W-1:0]    left_q;
    logic                skip_q;
    logic [NEEDLE_W-1:0] needle_q;
    logic                eq_q;
    logic                pend_q;
    logic [IDX_W-1:0]    pidx_q;
    logic                done_q;
    logic                zero_q;
    logic [ADDR_W-1:0]   ptr_q;

    logic                byte_eq;
    logic                cand_eq;
    logic [ADDR_W-1:0]   fetch_addr;
    logic [ADDR_W-1:0]   next_cand;
    logic                finish;
    logic [ADDR_W-1:0]   fin_ptr;
    logic                fin_zero;
    logic                busy_w;

    nwe_lane_match #(
        .NEEDLE_BYTES(NEEDLE_BYTES), .IDX_W(IDX_W), .NEEDLE_W(NEEDLE_W)
    ) u_match (
        .needle_i(needle_q), .lane_i(pidx_q), .data_i(mem_data_i), .eq_o(byte_eq)
    );

    nwe_ptr_step #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_step (
        .cand_i(cand_q), .idx_i(idx_q), .wlast_i(wlast_q), .skip_i(skip_q),
        .fetch_addr_o(fetch_addr), .next_cand_o(next_cand)
    );

    nwe_outcome #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_out (
        .skip_i(skip_q), .cand_eq_i(cand_eq), .left_i(left_q), .cand_i(cand_q),
        .next_cand_i(next_cand), .finish_o(finish), .fin_ptr_o(fin_ptr),
        .fin_zero_o(fin_zero)
    );

    // Compare result of the whole candidate once its last byte is back (R1).
    always_comb cand_eq = eq_q && byte_eq;

    // Read port driven straight from the fetch state (R10).
    always_comb begin
        mem_rd_o   = (state_q == ST_FETCH);
        mem_addr_o = fetch_addr;
    end

    // Walk in progress; also observed by the bound checker.
    always_comb busy_w = (state_q != ST_IDLE);

    // Track which issued byte returns in the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            pidx_q <= '0;
        end else begin
            pend_q <= (state_q == ST_FETCH);
            pidx_q <= idx_q;
        end
    end

    // Control: capture operands, fetch bytes, decide per candidate (R2-R8).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cand_q   <= '0;
            idx_q    <= '0;
            wlast_q  <= '0;
            left_q   <= '0;
            skip_q   <= 1'b0;
            needle_q <= '0;
            eq_q     <= 1'b1;
            done_q   <= 1'b0;
            zero_q   <= 1'b0;
            ptr_q    <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        cand_q   <= start_addr_i;
                        skip_q   <= skip_mode_i;
                        needle_q <= needle_i;
                        wlast_q  <= needle_len_i;
                        left_q   <= max_len_i;
                        idx_q    <= '0;
                        eq_q     <= 1'b1;
                        if (max_len_i == '0) begin
                            done_q <= 1'b1;
                            ptr_q  <= start_addr_i;
                            zero_q <= 1'b0;
                        end else begin
                            state_q <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: begin
                    idx_q <= idx_q + IDX_W'(1);
                    if (pend_q) eq_q <= eq_q && byte_eq;
                    if (idx_q == wlast_q) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (finish) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        ptr_q   <= fin_ptr;
                        zero_q  <= fin_zero;
                    end else begin
                        cand_q  <= next_cand;
                        left_q  <= left_q - LEN_W'(1);
                        idx_q   <= '0;
                        eq_q    <= 1'b1;
                        state_q <= ST_FETCH;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Result outputs are registers and hold between completions (R7).
    always_comb begin
        done_o = done_q;
        zero_o = zero_q;
        ptr_o  = ptr_q;
    end
endmodule

// File: rtl/nwe_checker.sv
// Protocol checker for needle_walk_engine, attached by bind. Observes the
// ports plus the engine's busy indication.
module nwe_checker #(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-1:0] start_addr_i,
    input logic [LEN_W-1:0]  max_len_i,
    input logic              mem_rd_o,
    input logic              done_o,
    input logic              zero_o,
    input logic [ADDR_W-1:0] ptr_o,
    input logic              busy
);
    // R7: completion pulse lasts one cycle.
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: completion coincides with the engine being idle.
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy);

    // R7: result outputs do not move during a walk.
    a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($stable(ptr_o) && $stable(zero_o)));

    // R10: no memory read outside a walk.
    a_r10_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> busy);

    // R6: empty range completes next cycle at the start address, flag clear.
    a_r6_empty_range: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_i && max_len_i == '0) |=>
            (done_o && !zero_o && ptr_o == $past(start_addr_i)));

    // R8: a start during a walk neither aborts nor restarts it.
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_i) |=> (busy || done_o));
endmodule

bind needle_walk_engine nwe_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_nwe_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .max_len_i(max_len_i), .mem_rd_o(mem_rd_o), .done_o(done_o),
    .zero_o(zero_o), .ptr_o(ptr_o), .busy(busy_w)
);

// File: tb/tb_needle_walk_engine.sv
`timescale 1ns/1ps
module tb_needle_walk_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        skip_mode_i = 1'b0;
    logic [23:0] start_addr_i = '0;
    logic [31:0] needle_i = '0;
    logic [1:0]  needle_len_i = '0;
    logic [23:0] max_len_i = '0;
    logic        mem_rd_o;
    logic [23:0] mem_addr_o;
    logic [7:0]  mem_data_i = '0;
    logic        done_o;
    logic        zero_o;
    logic [23:0] ptr_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    needle_walk_engine dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .skip_mode_i(skip_mode_i),
        .start_addr_i(start_addr_i), .needle_i(needle_i), .needle_len_i(needle_len_i),
        .max_len_i(max_len_i), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
        .mem_data_i(mem_data_i), .done_o(done_o), .zero_o(zero_o), .ptr_o(ptr_o)
    );

    // Memory model: 256-byte image aliased on the low address byte, 1-cycle read.
    logic [7:0] mem [256];
    always @(posedge clk) if (mem_rd_o) mem_data_i <= mem[mem_addr_o[7:0]];

    typedef struct packed {
        logic        skip;
        logic [23:0] sa;
        logic [31:0] nd;
        logic [1:0]  w;
        logic [23:0] len;
        logic [23:0] eptr;
        logic        ez;
        logic [7:0]  erd;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 24'h000010, 32'h00000041, 2'd0, 24'd16, 24'h000015, 1'b1, 8'd6,  4'd2}, // R2
        '{1'b0, 24'h000010, 32'h00004443, 2'd1, 24'd16, 24'h000017, 1'b1, 8'd16, 4'd1}, // R1 R2
        '{1'b0, 24'h000038, 32'h44332211, 2'd3, 24'd8,  24'h00003C, 1'b1, 8'd20, 4'd1}, // R1 partial then full
        '{1'b0, 24'h000020, 32'h0000ABCD, 2'd1, 24'd8,  24'h000021, 1'b1, 8'd4,  4'd1}, // R1 byte order
        '{1'b0, 24'h000010, 32'h00000099, 2'd0, 24'd5,  24'h000015, 1'b0, 8'd5,  4'd3}, // R3
        '{1'b1, 24'h000010, 32'h00000020, 2'd0, 24'd16, 24'h000015, 1'b1, 8'd6,  4'd4}, // R4 spaces
        '{1'b1, 24'h000020, 32'h0000CDAB, 2'd1, 24'd10, 24'h000024, 1'b1, 8'd6,  4'd4}, // R4 width step
        '{1'b1, 24'h000015, 32'h00000020, 2'd0, 24'd16, 24'h000015, 1'b1, 8'd1,  4'd4}, // R4 no move
        '{1'b1, 24'h000010, 32'h00000020, 2'd0, 24'd3,  24'h000013, 1'b0, 8'd3,  4'd5}, // R5
        '{1'b1, 24'h000020, 32'h0000CDAB, 2'd1, 24'd2,  24'h000024, 1'b0, 8'd4,  4'd5}, // R5 wide
        '{1'b0, 24'hFFFFFD, 32'h00000099, 2'd0, 24'd8,  24'h000001, 1'b1, 8'd5,  4'd9}, // R9 scan
        '{1'b1, 24'hFFFFFD, 32'h00005A5A, 2'd1, 24'd8,  24'h000001, 1'b1, 8'd6,  4'd9}, // R9 skip
        '{1'b1, 24'hFFFFFE, 32'h0000005A, 2'd0, 24'd2,  24'h000000, 1'b0, 8'd2,  4'd9}, // R9 R5
        '{1'b0, 24'h000055, 32'h00000012, 2'd0, 24'd0,  24'h000055, 1'b0, 8'd0,  4'd6}  // R6
    };

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    // Issue one start, then wait for done; counts reads and cycles (R10).
    task automatic run(input logic skip, input logic [23:0] sa, input logic [31:0] nd,
                       input logic [1:0] w, input logic [23:0] ln,
                       output logic [23:0] rp, output logic rz, output int rd, output int cyc);
        @(negedge clk);
        skip_mode_i = skip; start_addr_i = sa; needle_i = nd;
        needle_len_i = w; max_len_i = ln; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; rd = 0; cyc = 1;
        while (!done_o && cyc < 400) begin
            if (mem_rd_o) rd++;
            @(negedge clk);
            cyc++;
        end
        rp = ptr_o; rz = zero_o;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R7 watchdog act=hung exp=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [23:0] rp;
        logic        rz;
        int          rd;
        int          cyc;
        int          ndone;

        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        for (int i = 16; i < 21; i++) mem[i] = 8'h20;
        mem[8'h15] = 8'h41; mem[8'h16] = 8'h42; mem[8'h17] = 8'h43; mem[8'h18] = 8'h44;
        mem[8'h20] = 8'hAB; mem[8'h21] = 8'hCD; mem[8'h22] = 8'hAB; mem[8'h23] = 8'hCD;
        mem[8'h24] = 8'hAB;
        mem[8'h38] = 8'h11; mem[8'h39] = 8'h22; mem[8'h3A] = 8'h33; mem[8'h3B] = 8'h00;
        mem[8'h3C] = 8'h11; mem[8'h3D] = 8'h22; mem[8'h3E] = 8'h33; mem[8'h3F] = 8'h44;
        mem[8'hFD] = 8'h5A; mem[8'hFE] = 8'h5A; mem[8'hFF] = 8'h5A; mem[8'h00] = 8'h5A;
        mem[8'h01] = 8'h99;

        repeat (3) @(negedge clk);
        // R7 R10: reset state at the ports.
        chk("R7 reset done", 32'(done_o), 32'd0);
        chk("R7 reset ptr", 32'(ptr_o), 32'd0);
        chk("R7 reset zero", 32'(zero_o), 32'd0);
        chk("R10 reset read", 32'(mem_rd_o), 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run(VECS[i].skip, VECS[i].sa, VECS[i].nd, VECS[i].w, VECS[i].len, rp, rz, rd, cyc);
            chk($sformatf("R%0d vec%0d done seen", VECS[i].req, i), 32'(done_o), 32'd1);
            chk($sformatf("R%0d vec%0d ptr", VECS[i].req, i), 32'(rp), 32'(VECS[i].eptr));
            chk($sformatf("R%0d vec%0d zero", VECS[i].req, i), 32'(rz), 32'(VECS[i].ez));
            chk($sformatf("R10 vec%0d reads", i), 32'(rd), 32'(VECS[i].erd));
        end

        // R6: empty range finishes one cycle after start.
        run(1'b1, 24'h000077, 32'h0, 2'd2, 24'd0, rp, rz, rd, cyc);
        chk("R6 latency", 32'(cyc), 32'd1);
        chk("R6 ptr", 32'(rp), 32'h77);

        // R7: done for one cycle, result held afterwards.
        run(1'b1, 24'h000010, 32'h20, 2'd0, 24'd16, rp, rz, rd, cyc);
        @(negedge clk);
        chk("R7 done drops", 32'(done_o), 32'd0);
        repeat (3) @(negedge clk);
        chk("R7 ptr held", 32'(ptr_o), 32'h15);
        chk("R7 zero held", 32'(zero_o), 32'd1);

        // R8: a second start mid-walk must not disturb the first walk.
        @(negedge clk);
        skip_mode_i = 1'b0; start_addr_i = 24'h10; needle_i = 32'h41;
        needle_len_i = 2'd0; max_len_i = 24'd16; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (2) @(negedge clk);
        skip_mode_i = 1'b1; start_addr_i = 24'h30; max_len_i = 24'd0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        ndone = 0; cyc = 0;
        while (cyc < 40) begin
            if (done_o) begin
                ndone++;
                rp = ptr_o; rz = zero_o;
            end
            @(negedge clk);
            cyc++;
        end
        chk("R8 single done", 32'(ndone), 32'd1);
        chk("R8 ptr of first walk", 32'(rp), 32'h15);
        chk("R8 zero of first walk", 32'(rz), 32'd1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule